// File: doc/BRIEF.md
# Display Controller Serial Register Engine

This block is the host end of a serial link to a small display controller. A command gives one of four operations: set the index, write a register, read a register, or read status. Each command also carries an 8-bit register number and a 16-bit data word. The engine builds the framed byte sequences for the operation and drives the serial clock, the data-out line and an active-low chip select. It samples the data-in line and returns read results on a valid/ready stream.

Every frame opens with a start byte. The start byte carries a one-bit device identifier, a register-select bit and a direction bit. Two options are set per command:
- an option that complements every transmitted byte;
- a half-period setting for the serial clock. This setting is clamped to a floor so that register traffic never runs faster than the controller allows.

Commands come in over a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_valid` is ignored at any other time. Read results go out through `rsp_valid`/`rsp_ready`. When `rsp_ready` is low, the result is held unchanged and the engine stays busy. No further command is taken until the result has been accepted.

Top module: `dspi_reg_engine`

## Requirements
- R1: Each frame begins with a start byte laid out, MSB first, as the bits 0,1,1,1,0, then `cfg_id`, then RS, then RW. RS=0 addresses the index register and RS=1 addresses a register. RW=1 marks a read.
- R2: The index operation (`cmd_op`=0) sends one frame of three bytes: the start byte with RS=0 and RW=0, then 0x00, then `cmd_reg`.
- R3: The write operation (`cmd_op`=1) sends two frames. The first is the index frame of R2. The second holds the start byte with RS=1 and RW=0, then `cmd_data[15:8]`, then `cmd_data[7:0]`.
- R4: The read operation (`cmd_op`=2) sends two frames. The first is the index frame of R2. The second holds the start byte with RS=1 and RW=1, then two 0x00 bytes. The result is received byte 1 as the high byte and received byte 2 as the low byte.
- R5: The status operation (`cmd_op`=3) sends a single frame of four bytes: the start byte with RS=0 and RW=1, then three 0x00 bytes. Received byte 1 is discarded. The result is byte 2 as the high byte and byte 3 as the low byte.
- R6: Between two frames of one operation, `cs_n` stays high for at least one full serial clock period.
- R7: When `cfg_invert` is 1 at command acceptance, every transmitted byte of that operation is bitwise complemented.
- R8: The link runs in SPI mode 0, MSB first. `sclk` idles low. `mosi` changes only when `sclk` falls, and `miso` is sampled when `sclk` rises. Each half period of `sclk` lasts exactly max(`cfg_half_div`, MIN_HALF) clock cycles, with MIN_HALF defaulting to 7.
- R9: `busy` rises in the cycle after acceptance and stays high until the operation completes. While `busy` is high, `cmd_ready` is low and any `cmd_valid` is ignored.
- R10: A read or status result appears on `rsp_data` with `rsp_valid` high. It stays valid and unchanged until `rsp_ready` is high. Index and write operations produce no result.
- R11: While `rst_n` is low, `cs_n` is 1, `sclk` is 0, `busy` is 0, `rsp_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Operation: 0 index, 1 write, 2 read, 3 status |
| cmd_reg | input | 8 | Register number |
| cmd_data | input | 16 | Data word for writes |
| cfg_id | input | 1 | Device identifier bit placed in start bytes |
| cfg_invert | input | 1 | Complement all transmitted bytes |
| cfg_half_div | input | DIV_W (8) | Requested serial clock half period in cycles |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 16 | Read result |
| busy | output | 1 | Operation in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |
| cs_n | output | 1 | Active-low chip select |

## Verification
A behavioural controller model on the serial pins answers each of the four operations. It decodes the frames and returns register contents, so a wrong byte order, a frame split in the wrong place, or a missing dummy byte each shows up as a distinct frame or result mismatch. The tests run under both identifier values and with inversion on and off. Inversion on tells apart an engine that complements only some bytes. Half-period settings below, at and above the floor show whether the clamp and the divider both act. Holding back `rsp_ready` and offering commands mid-operation shows whether results are held and stray commands are dropped.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

  localparam int          BYTE_W    = 8;
  localparam logic [4:0]  START_TAG = 5'b01110;

  typedef enum logic [1:0] {
    OP_INDEX  = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_STATUS = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP,
    ST_RESP
  } st_e;

  function automatic logic [7:0] start_byte(input logic id, input logic rs, input logic rw);
    return {START_TAG, id, rs, rw};
  endfunction

  function automatic logic [1:0] frame_total(input op_e op);
    return (op == OP_INDEX || op == OP_STATUS) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [2:0] frame_bytes(input op_e op);
    return (op == OP_STATUS) ? 3'd4 : 3'd3;
  endfunction

  function automatic logic is_read(input op_e op);
    return (op == OP_READ) || (op == OP_STATUS);
  endfunction

  // Unencoded byte at position idx of frame fr for the given operation.
  function automatic logic [7:0] frame_byte(input op_e op, input logic fr,
                                            input logic [1:0] idx, input logic [7:0] rg,
                                            input logic [15:0] dat, input logic id);
    logic [7:0] b;
    b = 8'h00;
    if (op == OP_STATUS) begin
      if (idx == 2'd0) b = start_byte(id, 1'b0, 1'b1);
    end else if (!fr) begin
      if (idx == 2'd0)      b = start_byte(id, 1'b0, 1'b0);
      else if (idx == 2'd2) b = rg;
    end else begin
      if (idx == 2'd0)                          b = start_byte(id, 1'b1, op == OP_READ);
      else if (idx == 2'd1 && op == OP_WRITE)   b = dat[15:8];
      else if (idx == 2'd2 && op == OP_WRITE)   b = dat[7:0];
    end
    return b;
  endfunction

endpackage

// File: rtl/dspi_tick_gen.sv
module dspi_tick_gen #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] cnt;

  assign eff  = (half < FLOOR) ? FLOOR : half;
  assign tick = en && (cnt == eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // Half periods are never shorter than two cycles, so ticks never touch.
  assert_tick_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dspi_byte_shifter.sv
module dspi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  input  logic       nxt_valid,
  input  logic [7:0] nxt_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0] sh;
  logic [7:0] rx;
  logic [2:0] bitn;
  logic       sclk_q;

  assign sclk    = sclk_q;
  assign mosi    = sh[7];
  assign rx_byte = rx;
  assign done    = tick && sclk_q && (bitn == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      rx     <= '0;
      bitn   <= '0;
      sclk_q <= 1'b0;
    end else if (load) begin
      sh     <= load_byte;
      bitn   <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx     <= {rx[6:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (bitn == 3'd7) begin
          bitn <= '0;
          if (nxt_valid) sh <= nxt_byte;
        end else begin
          bitn <= bitn + 3'd1;
          sh   <= {sh[6:0], 1'b0};
        end
      end
    end
  end

  // Mode 0: data out never moves on a rising serial clock edge.
  assert_mosi_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sh[7]));

endmodule

// File: rtl/dspi_reg_engine.sv
module dspi_reg_engine
  import dspi_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MIN_HALF  = 7,
  parameter int GAP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_reg,
  input  logic [15:0]      cmd_data,
  input  logic             cfg_id,
  input  logic             cfg_invert,
  input  logic [DIV_W-1:0] cfg_half_div,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [15:0]      rsp_data,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int GAP_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);

  st_e              st;
  op_e              op_q;
  logic [7:0]       reg_q;
  logic [15:0]      dat_q;
  logic             id_q, inv_q, fr_q, cs_n_q;
  logic [1:0]       idx_q;
  logic [GAP_W-1:0] gap_q;
  logic [DIV_W-1:0] half_q;
  logic [15:0]      res_q;

  logic       accept, tick, shift_tick, tick_en, done;
  logic       last_byte, last_frame, gap_end, load;
  logic [7:0] load_byte, nxt_byte, rx_byte;

  assign accept     = cmd_valid && (st == ST_IDLE);
  assign tick_en    = (st == ST_LEAD) || (st == ST_SHIFT) || (st == ST_GAP);
  assign shift_tick = tick && (st == ST_SHIFT);
  assign last_byte  = ({1'b0, idx_q} == frame_bytes(op_q) - 3'd1);
  assign last_frame = ({1'b0, fr_q} == frame_total(op_q) - 2'd1);
  assign gap_end    = (st == ST_GAP) && tick && (gap_q == GAP_LAST);

  assign nxt_byte = frame_byte(op_q, fr_q, idx_q + 2'd1, reg_q, dat_q, id_q) ^ {8{inv_q}};

  always_comb begin
    load      = 1'b0;
    load_byte = 8'h00;
    if (accept) begin
      load      = 1'b1;
      load_byte = frame_byte(op_e'(cmd_op), 1'b0, 2'd0, cmd_reg, cmd_data, cfg_id)
                  ^ {8{cfg_invert}};
    end else if (gap_end && !last_frame) begin
      load      = 1'b1;
      load_byte = frame_byte(op_q, 1'b1, 2'd0, reg_q, dat_q, id_q) ^ {8{inv_q}};
    end
  end

  dspi_tick_gen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .half(half_q), .tick(tick)
  );

  dspi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .tick(shift_tick), .nxt_valid(!last_byte), .nxt_byte(nxt_byte),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= OP_INDEX;
      reg_q  <= '0;
      dat_q  <= '0;
      id_q   <= 1'b0;
      inv_q  <= 1'b0;
      half_q <= '0;
      fr_q   <= 1'b0;
      idx_q  <= '0;
      gap_q  <= '0;
      res_q  <= '0;
      cs_n_q <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          op_q   <= op_e'(cmd_op);
          reg_q  <= cmd_reg;
          dat_q  <= cmd_data;
          id_q   <= cfg_id;
          inv_q  <= cfg_invert;
          half_q <= cfg_half_div;
          fr_q   <= 1'b0;
          idx_q  <= '0;
          cs_n_q <= 1'b0;
          st     <= ST_LEAD;
        end
        ST_LEAD: if (tick) st <= ST_SHIFT;
        ST_SHIFT: if (done) begin
          // Result keeps the last two bytes of the final frame.
          if (is_read(op_q) && last_frame) res_q <= {res_q[7:0], rx_byte};
          if (last_byte) begin
            cs_n_q <= 1'b1;
            gap_q  <= '0;
            st     <= ST_GAP;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q == GAP_LAST) begin
            if (!last_frame) begin
              fr_q   <= 1'b1;
              idx_q  <= '0;
              cs_n_q <= 1'b0;
              st     <= ST_LEAD;
            end else begin
              st <= is_read(op_q) ? ST_RESP : ST_IDLE;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_data  = res_q;
  assign cs_n      = cs_n_q;

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

endmodule

// File: tb/dspi_reg_engine_test.sv
module dspi_reg_engine_test;
  localparam int FLOOR = 7;
  localparam logic [15:0] STAT_WORD = 16'h9C21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_reg = 8'h00;
  logic [15:0] cmd_data = 16'h0000;
  logic cfg_id = 1'b1, cfg_invert = 1'b0;
  logic [7:0] cfg_half_div = 8'd0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic busy, sclk, mosi, cs_n;
  logic miso_b = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  logic slave_on = 1'b0;

  logic [15:0] model_mem [256];
  logic [15:0] slave_mem [256];
  logic [31:0] exp_fr_q[$];
  int          exp_len_q[$];
  string       exp_tag_q[$];
  logic [15:0] exp_rsp_q[$];
  string       exp_rtag_q[$];

  logic [7:0]  s_sh, s_tx, s_idx, s_raw0;
  logic [31:0] s_acc;
  logic        s_rs, s_rw;
  int s_bits, s_nb, last_rise, min_sp, max_sp, cs_rise_t, last_gap;

  dspi_reg_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cfg_id(cfg_id),
    .cfg_invert(cfg_invert), .cfg_half_div(cfg_half_div), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso_b), .cs_n(cs_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] sb(input logic rs, input logic rw);
    return {5'b01110, cfg_id, rs, rw};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- controller model on the serial pins ----------------
  always @(negedge cs_n) if (slave_on) begin
    s_bits = 0; s_nb = 0; s_acc = '0; s_tx = 8'h00; miso_b = 1'b0;
    last_rise = -1; last_gap = cyc - cs_rise_t;
  end

  always @(posedge sclk) if (slave_on && !cs_n) begin
    logic [7:0] b;
    if (last_rise >= 0) begin
      if (cyc - last_rise < min_sp) min_sp = cyc - last_rise;
      if (cyc - last_rise > max_sp) max_sp = cyc - last_rise;
    end
    last_rise = cyc;
    s_sh = {s_sh[6:0], mosi};
    s_bits++;
    if (s_bits == 8) begin
      s_bits = 0;
      b = s_sh ^ {8{cfg_invert}};
      if (s_nb == 0) begin s_raw0 = s_sh; s_rs = b[1]; s_rw = b[0]; end
      s_acc = {s_acc[23:0], b};
      s_nb++;
      s_tx = 8'h00;
      if (s_rs && s_rw) begin
        if (s_nb == 1) s_tx = slave_mem[s_idx][15:8];
        else if (s_nb == 2) s_tx = slave_mem[s_idx][7:0];
      end else if (!s_rs && s_rw) begin
        if (s_nb == 1) s_tx = 8'h3C;
        else if (s_nb == 2) s_tx = STAT_WORD[15:8];
        else if (s_nb == 3) s_tx = STAT_WORD[7:0];
      end
    end
  end

  always @(negedge sclk) if (slave_on && !cs_n) miso_b = s_tx[3'(7 - s_bits)];

  always @(posedge cs_n) if (slave_on) begin
    logic [31:0] got;
    cs_rise_t = cyc;
    if (!s_rs && !s_rw && s_nb == 3) s_idx = s_acc[7:0];
    if (s_rs && !s_rw && s_nb == 3) slave_mem[s_idx] = s_acc[15:0];
    got = s_acc << (8 * (4 - s_nb));
    if (exp_fr_q.size() == 0) begin
      check(1'b0, "R9", "unexpected frame", got, 32'h0);
    end else begin
      logic [31:0] e; int n; string t;
      e = exp_fr_q.pop_front(); n = exp_len_q.pop_front(); t = exp_tag_q.pop_front();
      check(got == e && s_nb == n, t, "frame bytes", got, e);
    end
  end

  // ---------------- response monitor ----------------
  always @(negedge clk) if (rst_n && rsp_valid && rsp_ready) begin
    if (exp_rsp_q.size() == 0) begin
      check(1'b0, "R10", "response without read", {16'h0, rsp_data}, 32'h0);
    end else begin
      logic [15:0] e; string t;
      e = exp_rsp_q.pop_front(); t = exp_rtag_q.pop_front();
      check(rsp_data == e, t, "read result", {16'h0, rsp_data}, {16'h0, e});
    end
  end

  // ---------------- driver ----------------
  task automatic push_fr(input logic [31:0] f, input int n, input string t);
    exp_fr_q.push_back(f); exp_len_q.push_back(n); exp_tag_q.push_back(t);
  endtask

  task automatic launch(input logic [1:0] op, input logic [7:0] rg,
                        input logic [15:0] dat, input string tag);
    if (op != 2'd3) push_fr({sb(1'b0, 1'b0), 8'h00, rg, 8'h00}, 3, tag);
    case (op)
      2'd1: begin
        push_fr({sb(1'b1, 1'b0), dat, 8'h00}, 3, tag);
        model_mem[rg] = dat;
      end
      2'd2: begin
        push_fr({sb(1'b1, 1'b1), 24'h0}, 3, tag);
        exp_rsp_q.push_back(model_mem[rg]); exp_rtag_q.push_back(tag);
      end
      2'd3: begin
        push_fr({sb(1'b0, 1'b1), 24'h0}, 4, tag);
        exp_rsp_q.push_back(STAT_WORD); exp_rtag_q.push_back(tag);
      end
      default: ;
    endcase
    min_sp = 1000000; max_sp = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_reg = rg; cmd_data = dat;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] rg,
                         input logic [15:0] dat, input string tag);
    int eff;
    launch(op, rg, dat, tag);
    wait_idle();
    eff = (cfg_half_div < FLOOR) ? FLOOR : int'(cfg_half_div);
    check(min_sp == 2 * eff && max_sp == 2 * eff, "R8", "sclk period",
          32'(min_sp), 32'(2 * eff));
    if (op == 2'd1 || op == 2'd2)
      check(last_gap >= 2 * eff, "R6", "cs_n gap", 32'(last_gap), 32'(2 * eff));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = {i[7:0], ~i[7:0]};
      slave_mem[i] = {i[7:0], ~i[7:0]};
    end
    cs_rise_t = 0; last_gap = 0; s_idx = 8'h00; s_rs = 1'b0; s_rw = 1'b0;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(cs_n === 1'b1 && sclk === 1'b0, "R11", "cs_n/sclk in reset",
          {30'h0, cs_n, sclk}, 32'h2);
    check(busy === 1'b0 && rsp_valid === 1'b0 && cmd_ready === 1'b1, "R11",
          "handshake in reset", {29'h0, busy, rsp_valid, cmd_ready}, 32'h1);
    rst_n = 1'b1;
    slave_on = 1'b1;
    repeat (3) @(negedge clk);

    run_cmd(2'd0, 8'h22, 16'h0000, "R2");
    run_cmd(2'd1, 8'h10, 16'hBEEF, "R3");
    run_cmd(2'd2, 8'h10, 16'h0000, "R4");
    run_cmd(2'd2, 8'h05, 16'h0000, "R4");
    run_cmd(2'd3, 8'h00, 16'h0000, "R5");

    cfg_id = 1'b0;                          // R1 with the other identifier
    run_cmd(2'd1, 8'h33, 16'h1234, "R1");
    run_cmd(2'd2, 8'h33, 16'h0000, "R1");
    run_cmd(2'd3, 8'h00, 16'h0000, "R1");

    cfg_invert = 1'b1;                      // R7 inversion
    run_cmd(2'd1, 8'h40, 16'h0F5A, "R7");
    run_cmd(2'd2, 8'h40, 16'h0000, "R7");
    run_cmd(2'd3, 8'h00, 16'h0000, "R7");
    check(s_raw0 == 8'h8E, "R7", "raw start byte on wire", {24'h0, s_raw0}, 32'h8E);
    cfg_invert = 1'b0;
    cfg_id = 1'b1;

    cfg_half_div = 8'd10;                   // R8 divider above the floor
    run_cmd(2'd2, 8'h7F, 16'h0000, "R8");
    cfg_half_div = 8'd1;                    // R8 clamp
    run_cmd(2'd2, 8'h80, 16'h0000, "R8");
    cfg_half_div = 8'd0;

    // R10 back-pressure on the result
    rsp_ready = 1'b0;
    launch(2'd2, 8'h10, 16'h0000, "R10");
    while (!rsp_valid) @(negedge clk);
    begin
      logic [15:0] held; bit ok;
      held = rsp_data; ok = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (!rsp_valid || rsp_data != held || cmd_ready) ok = 1'b0;
      end
      check(ok, "R10", "result held under back-pressure", {16'h0, rsp_data}, {16'h0, held});
    end
    rsp_ready = 1'b1;
    wait_idle();

    // R9 commands offered while busy are dropped
    launch(2'd1, 8'h55, 16'hA0A0, "R9");
    repeat (50) @(negedge clk);
    begin
      bit ok; ok = 1'b1;
      cmd_valid = 1'b1; cmd_op = 2'd3;
      repeat (20) begin
        @(negedge clk);
        if (cmd_ready || !busy) ok = 1'b0;
      end
      cmd_valid = 1'b0;
      check(ok, "R9", "busy high and not ready mid-operation", {31'h0, cmd_ready}, 32'h0);
    end
    wait_idle();
    repeat (60) @(negedge clk);
    check(exp_fr_q.size() == 0 && cs_n, "R9", "no frame from dropped command",
          32'(exp_fr_q.size()), 32'h0);
    check(exp_rsp_q.size() == 0, "R10", "all results delivered, none for writes",
          32'(exp_rsp_q.size()), 32'h0);
    run_cmd(2'd2, 8'h55, 16'h0000, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule